// File: doc/BRIEF.md
# Register and Predicate Remap Table

This block classifies the register operands of an instruction as scalar or vector. It holds two small associative tables that are loaded through a plain configuration write port. The register table maps an architectural register to a vector flag, a first physical register and an element-width code. The predicate table maps an architectural register to the register that holds its mask, together with an invert flag and a zeroing flag.

Each lookup port takes a register-file select bit and a 5-bit register number. It searches both tables in parallel and returns registered results one cycle later. A miss means the operand is plain scalar. Several entries may carry the same key, and the entry with the lowest index takes precedence. A delete command clears the addressed entry and every entry above it.

Top module: `vreg_remap_table`

## Requirements
- R1: After synchronous reset every entry in both tables is invalid, so every lookup misses and every lookup output reads 0.
- R2: An entry key is the pair {file select bit (0 integer, 1 floating point), 5-bit register number}. A lookup hits only when both parts match a valid entry. Results appear on the outputs at the first rising edge after the query is presented.
- R3: On a register-table hit, vec_hit is 1 and vec_base and vec_ew carry the stored start register and the 3-bit width code. On a miss all three read 0, which means scalar.
- R4: On a predicate-table hit, pred_hit is 1, pred_reg is the stored mask register, pred_inv is cfg_attr bit 0 as written, and pred_zero is cfg_attr bit 1 as written. On a miss all four read 0.
- R5: When several valid entries of one table match the same key, the lowest-indexed entry supplies the result.
- R6: cfg_del with index k invalidates entries k and above in the table chosen by cfg_tbl and leaves entries below k unchanged. If cfg_del and cfg_we are both high, the delete wins.
- R7: Width codes 0 (default), 1 (8-bit), 2 (16-bit), 3 (32-bit) and 4 (64-bit) are legal. Codes 5 to 7 are reserved. ew_bad is 1 exactly when a register-table hit returns a reserved code.
- R8: A lookup made in the same cycle as a write to the matching entry returns the contents from before the write. The new contents appear from the next lookup on.
- R9: Each lookup port is evaluated independently in the same cycle, and each port returns its own key's result.
- R10: cfg_tbl=0 writes the register table and cfg_tbl=1 writes the predicate table. A write or delete in one table leaves the other table's results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one entry |
| cfg_del | input | 1 | Delete entry cfg_idx and all higher entries |
| cfg_tbl | input | 1 | 0 register table, 1 predicate table |
| cfg_idx | input | 3 | Entry index |
| cfg_fp | input | 1 | Key file select |
| cfg_key | input | 5 | Key register number |
| cfg_dst | input | 5 | Start register or mask register |
| cfg_attr | input | 3 | Width code, or {-, zero, invert} |
| lk_fp | input | 2 | Per-port file select |
| lk_reg | input | 10 | Per-port register number, 5 bits each |
| vec_hit | output | 2 | Per-port register-table hit |
| vec_base | output | 10 | Per-port start register |
| vec_ew | output | 6 | Per-port width code |
| ew_bad | output | 2 | Per-port reserved width flag |
| pred_hit | output | 2 | Per-port predicate-table hit |
| pred_reg | output | 10 | Per-port mask register |
| pred_inv | output | 2 | Per-port invert flag |
| pred_zero | output | 2 | Per-port zeroing flag |

## Verification
A configuration write takes effect at the rising edge on which it is sampled. A lookup result is valid from the rising edge after the query is presented, and it reflects the table as it stood before that edge. The bench changes its inputs on falling edges and samples outputs on the next falling edge. Each sample therefore sits exactly one rising edge after its stimulus. The same-cycle test sets a write and a lookup on one falling edge, expects the old value at the next falling edge, and expects the new value one edge later.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int RN_W = 5;
  localparam int EW_W = 3;
  localparam int KEY_W = RN_W + 1;

  typedef enum logic [EW_W-1:0] {
    EW_DEF = 3'd0,
    EW_8   = 3'd1,
    EW_16  = 3'd2,
    EW_32  = 3'd3,
    EW_64  = 3'd4
  } ew_code_e;

  function automatic logic ew_reserved(input logic [EW_W-1:0] c);
    return c > EW_64;
  endfunction
endpackage

// File: rtl/remap_cam.sv
module remap_cam #(
  parameter int ENTRIES = 8,
  parameter int KEY_W = 6,
  parameter int VAL_W = 8,
  parameter int NPORT = 2,
  parameter int IDX_W = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   del_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [KEY_W-1:0]       wr_key,
  input  logic [VAL_W-1:0]       wr_val,
  input  logic [NPORT*KEY_W-1:0] q_key,
  output logic [NPORT-1:0]       q_hit,
  output logic [NPORT*VAL_W-1:0] q_val
);
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  // valid bits: reset, delete-upward, set on write
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (del_en) begin
      for (int j = 0; j < ENTRIES; j++)
        if (j >= int'(wr_idx)) valid_q[j] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !del_en) begin
      key_q[wr_idx] <= wr_key;
      val_q[wr_idx] <= wr_val;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic             h;
    logic [VAL_W-1:0] v;
    always_comb begin
      h = 1'b0;
      v = '0;
      // scan downward so the lowest matching index is assigned last
      for (int j = ENTRIES - 1; j >= 0; j--) begin
        if (valid_q[j] && key_q[j] == q_key[p*KEY_W +: KEY_W]) begin
          h = 1'b1;
          v = val_q[j];
        end
      end
    end
    assign q_hit[p] = h;
    assign q_val[p*VAL_W +: VAL_W] = v;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> valid_q == '0);

  assert_delete_upward_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(del_en) |-> (valid_q >> $past(wr_idx)) == '0);

  assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(wr_en) && !$past(del_en) |-> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/remap_port_reg.sv
module remap_port_reg
  import remap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            r_hit,
  input  logic [RN_W-1:0] r_base,
  input  logic [EW_W-1:0] r_ew,
  input  logic            p_hit,
  input  logic [RN_W-1:0] p_reg,
  input  logic [1:0]      p_flags,
  output logic            vec_hit,
  output logic [RN_W-1:0] vec_base,
  output logic [EW_W-1:0] vec_ew,
  output logic            ew_bad,
  output logic            pred_hit,
  output logic [RN_W-1:0] pred_reg,
  output logic            pred_inv,
  output logic            pred_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_hit   <= 1'b0;
      vec_base  <= '0;
      vec_ew    <= '0;
      ew_bad    <= 1'b0;
      pred_hit  <= 1'b0;
      pred_reg  <= '0;
      pred_inv  <= 1'b0;
      pred_zero <= 1'b0;
    end else begin
      vec_hit   <= r_hit;
      vec_base  <= r_base;
      vec_ew    <= r_ew;
      ew_bad    <= r_hit && ew_reserved(r_ew);
      pred_hit  <= p_hit;
      pred_reg  <= p_reg;
      pred_inv  <= p_flags[0];
      pred_zero <= p_flags[1];
    end
  end

  assert_bad_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
    ew_bad |-> vec_hit && vec_ew > 3'd4);

  assert_vec_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !vec_hit |-> vec_base == '0 && vec_ew == '0);

  assert_pred_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> pred_reg == '0 && !pred_inv && !pred_zero);
endmodule

// File: rtl/vreg_remap_table.sv
module vreg_remap_table
  import remap_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NPORT = 2,
  parameter int IDX_W = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic                  cfg_del,
  input  logic                  cfg_tbl,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic                  cfg_fp,
  input  logic [RN_W-1:0]       cfg_key,
  input  logic [RN_W-1:0]       cfg_dst,
  input  logic [EW_W-1:0]       cfg_attr,
  input  logic [NPORT-1:0]      lk_fp,
  input  logic [NPORT*RN_W-1:0] lk_reg,
  output logic [NPORT-1:0]      vec_hit,
  output logic [NPORT*RN_W-1:0] vec_base,
  output logic [NPORT*EW_W-1:0] vec_ew,
  output logic [NPORT-1:0]      ew_bad,
  output logic [NPORT-1:0]      pred_hit,
  output logic [NPORT*RN_W-1:0] pred_reg,
  output logic [NPORT-1:0]      pred_inv,
  output logic [NPORT-1:0]      pred_zero
);
  localparam int RVAL_W = RN_W + EW_W;
  localparam int PVAL_W = RN_W + 2;

  logic [NPORT*KEY_W-1:0]  q_key;
  logic [NPORT-1:0]        r_hit, p_hit;
  logic [NPORT*RVAL_W-1:0] r_val;
  logic [NPORT*PVAL_W-1:0] p_val;

  for (genvar p = 0; p < NPORT; p++) begin : g_key
    assign q_key[p*KEY_W +: KEY_W] = {lk_fp[p], lk_reg[p*RN_W +: RN_W]};
  end

  remap_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .VAL_W(RVAL_W), .NPORT(NPORT), .IDX_W(IDX_W)) u_rtab (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we && !cfg_tbl), .del_en(cfg_del && !cfg_tbl),
    .wr_idx(cfg_idx), .wr_key({cfg_fp, cfg_key}), .wr_val({cfg_attr, cfg_dst}),
    .q_key(q_key), .q_hit(r_hit), .q_val(r_val)
  );

  remap_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .VAL_W(PVAL_W), .NPORT(NPORT), .IDX_W(IDX_W)) u_ptab (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we && cfg_tbl), .del_en(cfg_del && cfg_tbl),
    .wr_idx(cfg_idx), .wr_key({cfg_fp, cfg_key}), .wr_val({cfg_attr[1:0], cfg_dst}),
    .q_key(q_key), .q_hit(p_hit), .q_val(p_val)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    remap_port_reg u_reg (
      .clk(clk), .rst(rst),
      .r_hit(r_hit[p]),
      .r_base(r_val[p*RVAL_W +: RN_W]),
      .r_ew(r_val[p*RVAL_W + RN_W +: EW_W]),
      .p_hit(p_hit[p]),
      .p_reg(p_val[p*PVAL_W +: RN_W]),
      .p_flags(p_val[p*PVAL_W + RN_W +: 2]),
      .vec_hit(vec_hit[p]),
      .vec_base(vec_base[p*RN_W +: RN_W]),
      .vec_ew(vec_ew[p*EW_W +: EW_W]),
      .ew_bad(ew_bad[p]),
      .pred_hit(pred_hit[p]),
      .pred_reg(pred_reg[p*RN_W +: RN_W]),
      .pred_inv(pred_inv[p]),
      .pred_zero(pred_zero[p])
    );
  end
endmodule

// File: tb/tb_vreg_remap_table.sv
module tb_vreg_remap_table;
  logic clk = 1'b0;
  logic rst;
  logic cfg_we, cfg_del, cfg_tbl, cfg_fp;
  logic [2:0] cfg_idx, cfg_attr;
  logic [4:0] cfg_key, cfg_dst;
  logic [1:0] lk_fp;
  logic [9:0] lk_reg;
  logic [1:0] vec_hit, ew_bad, pred_hit, pred_inv, pred_zero;
  logic [9:0] vec_base, pred_reg;
  logic [5:0] vec_ew;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vreg_remap_table dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_del(cfg_del), .cfg_tbl(cfg_tbl),
    .cfg_idx(cfg_idx), .cfg_fp(cfg_fp), .cfg_key(cfg_key), .cfg_dst(cfg_dst),
    .cfg_attr(cfg_attr), .lk_fp(lk_fp), .lk_reg(lk_reg), .vec_hit(vec_hit),
    .vec_base(vec_base), .vec_ew(vec_ew), .ew_bad(ew_bad), .pred_hit(pred_hit),
    .pred_reg(pred_reg), .pred_inv(pred_inv), .pred_zero(pred_zero)
  );

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic set_lk(input int p, input logic fp, input logic [4:0] r);
    lk_fp[p] = fp;
    lk_reg[p*5 +: 5] = r;
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic cfg(input logic tbl, input logic del, input logic [2:0] idx,
                     input logic fp, input logic [4:0] key, input logic [4:0] dst,
                     input logic [2:0] attr);
    cfg_tbl = tbl; cfg_del = del; cfg_we = 1'b1; cfg_idx = idx;
    cfg_fp = fp; cfg_key = key; cfg_dst = dst; cfg_attr = attr;
    @(negedge clk);
    cfg_we = 1'b0; cfg_del = 1'b0;
  endtask

  // present a query on port 0 and sample one rising edge later
  task automatic look0(input logic fp, input logic [4:0] r);
    set_lk(0, fp, r);
    @(negedge clk);
  endtask

  task automatic t_reset();
    look0(1'b0, 5'd5);
    check("R1 vec_hit after reset", vec_hit[0], 0);
    check("R1 pred_hit after reset", pred_hit[0], 0);
    check("R1 vec_base after reset", vec_base[4:0], 0);
  endtask

  task automatic t_basic();
    cfg(1'b0, 1'b0, 3'd0, 1'b0, 5'd5, 5'd10, 3'd3);
    look0(1'b0, 5'd5);
    check("R3 hit", vec_hit[0], 1);
    check("R3 base", vec_base[4:0], 10);
    check("R3 ew", vec_ew[2:0], 3);
    check("R7 legal code no flag", ew_bad[0], 0);
    look0(1'b1, 5'd5);
    check("R2 other file misses", vec_hit[0], 0);
    look0(1'b0, 5'd6);
    check("R3 miss hit", vec_hit[0], 0);
    check("R3 miss base", vec_base[4:0], 0);
  endtask

  task automatic t_pred();
    cfg(1'b1, 1'b0, 3'd0, 1'b1, 5'd7, 5'd3, 3'b001);
    look0(1'b1, 5'd7);
    check("R4 pred hit", pred_hit[0], 1);
    check("R4 pred reg", pred_reg[4:0], 3);
    check("R4 invert bit0", pred_inv[0], 1);
    check("R4 zero bit1", pred_zero[0], 0);
    check("R10 reg table untouched", vec_hit[0], 0);
    cfg(1'b1, 1'b0, 3'd1, 1'b0, 5'd8, 5'd4, 3'b010);
    look0(1'b0, 5'd8);
    check("R4 zero flag", pred_zero[0], 1);
    check("R4 inv clear", pred_inv[0], 0);
  endtask

  task automatic t_multi();
    cfg(1'b0, 1'b0, 3'd3, 1'b0, 5'd9, 5'd20, 3'd1);
    cfg(1'b0, 1'b0, 3'd1, 1'b0, 5'd9, 5'd21, 3'd2);
    look0(1'b0, 5'd9);
    check("R5 lowest index wins base", vec_base[4:0], 21);
    check("R5 lowest index wins ew", vec_ew[2:0], 2);
  endtask

  task automatic t_ports();
    set_lk(0, 1'b0, 5'd5);
    set_lk(1, 1'b0, 5'd9);
    @(negedge clk);
    check("R9 port0 base", vec_base[4:0], 10);
    check("R9 port1 base", vec_base[9:5], 21);
    check("R9 port1 hit", vec_hit[1], 1);
    set_lk(1, 1'b0, 5'd0);
  endtask

  task automatic t_same_cycle();
    set_lk(0, 1'b0, 5'd5);
    cfg_tbl = 1'b0; cfg_del = 1'b0; cfg_we = 1'b1; cfg_idx = 3'd0;
    cfg_fp = 1'b0; cfg_key = 5'd5; cfg_dst = 5'd12; cfg_attr = 3'd4;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 old contents same cycle", vec_base[4:0], 10);
    @(negedge clk);
    check("R8 new contents next cycle", vec_base[4:0], 12);
  endtask

  task automatic t_ew();
    cfg(1'b0, 1'b0, 3'd2, 1'b0, 5'd11, 5'd1, 3'd5);
    look0(1'b0, 5'd11);
    check("R7 reserved code flagged", ew_bad[0], 1);
    cfg(1'b0, 1'b0, 3'd2, 1'b0, 5'd11, 5'd1, 3'd7);
    look0(1'b0, 5'd11);
    check("R7 code 7 flagged", ew_bad[0], 1);
    cfg(1'b0, 1'b0, 3'd2, 1'b0, 5'd11, 5'd1, 3'd4);
    look0(1'b0, 5'd11);
    check("R7 64-bit code legal", ew_bad[0], 0);
    look0(1'b0, 5'd12);
    check("R7 miss no flag", ew_bad[0], 0);
  endtask

  task automatic t_delete();
    cfg(1'b0, 1'b1, 3'd1, 1'b0, 5'd0, 5'd0, 3'd0);
    look0(1'b0, 5'd9);
    check("R6 idx1 and idx3 cleared", vec_hit[0], 0);
    look0(1'b0, 5'd11);
    check("R6 idx2 cleared", vec_hit[0], 0);
    look0(1'b0, 5'd5);
    check("R6 idx0 kept", vec_hit[0], 1);
    look0(1'b1, 5'd7);
    check("R10 pred table kept", pred_hit[0], 1);
    // delete and write at once: delete wins
    cfg_tbl = 1'b0; cfg_del = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd0;
    cfg_fp = 1'b0; cfg_key = 5'd5; cfg_dst = 5'd30; cfg_attr = 3'd0;
    @(negedge clk);
    cfg_we = 1'b0; cfg_del = 1'b0;
    look0(1'b0, 5'd5);
    check("R6 delete beats write", vec_hit[0], 0);
    cfg(1'b1, 1'b1, 3'd1, 1'b0, 5'd0, 5'd0, 3'd0);
    look0(1'b0, 5'd8);
    check("R6 pred idx1 deleted", pred_hit[0], 0);
    look0(1'b1, 5'd7);
    check("R6 pred idx0 below kept", pred_hit[0], 1);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_del = 1'b0; cfg_tbl = 1'b0; cfg_idx = '0;
    cfg_fp = 1'b0; cfg_key = '0; cfg_dst = '0; cfg_attr = '0;
    lk_fp = '0; lk_reg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_pred();
    t_multi();
    t_ports();
    t_same_cycle();
    t_ew();
    t_delete();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule